// File: doc/BRIEF.md
# Half-Bridge Gate Driver with Dead-Time Insertion

This block turns a single pulse-width command into a pair of complementary gate drives for the two switches of a half-bridge. The high-side drive follows the command when it is high, and the low-side drive follows it when it is low. Each time the command changes level, the conducting switch is released on the next clock edge. The opposite switch is then held off for a programmable number of clock cycles before it is allowed to turn on. This keeps the two switches from ever conducting together.

A trip input shuts both drives off on the next clock edge. The shutdown stays latched until a clear strobe arrives while the trip input is low. After a clear, after reset, and after every command edge, the incoming side always waits for the whole idle interval. A command pulse that is shorter than that interval never reaches the gates. The idle timer then restarts from the pulse's trailing edge.

Top module: `cpwm_deadband`

## Requirements
- R1: While a drive is on, it matches the command sampled at the previous edge: `gate_hi` only when the command was 1, `gate_lo` only when it was 0.
- R2: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R3: When a clock edge samples a command different from the one sampled at the edge before, the drive that was on is 0 right after that edge.
- R4: With setting G on `gap_cycles`, the incoming drive turns on at the (G+1)-th edge after the edge that saw the command change. A command level held for L cycles therefore yields max(0, L-G-1) cycles of drive.
- R5: When a command level lasts no more than G+1 cycles, its drive never turns on. The idle count restarts from the next command edge, so the following level again gets exactly max(0, L-G-1) drive cycles.
- R6: A `trip` value of 1 sampled at an edge makes both drives 0 right after that edge, even if the command changes at the same edge.
- R7: The shutdown stays in force after `trip` returns to 0. It ends only at an edge that samples `trip_clear`=1 together with `trip`=0. A clear given while `trip`=1 is ignored.
- R8: After the clearing edge, the drive selected by the command turns on at the (G+1)-th edge after it.
- R9: With G=0, the two drives still alternate with exactly one cycle in which both are 0 at each command edge.
- R10: Reset (`rst_n`=0) forces both drives to 0 at once. After release, with the command held at 0, `gate_lo` first turns on at the (G+1)-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_cmd | input | 1 | Pulse-width command: 1 selects high side, 0 selects low side |
| gap_cycles | input | GAP_W | Idle cycles G inserted at each change of side |
| trip | input | 1 | Fault request, forces both drives off and latches |
| trip_clear | input | 1 | Releases the latched fault when trip is 0 |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
Two functions can fall on the same edge: a command transition and a trip. A clear strobe can also coincide with a still-active trip. The bench raises `trip` on the same edge at which the command flips from high to low. It then requires both drives to be off after that edge and to stay off, so the transition must not start a low-side idle count that later turns `gate_lo` on. It then pulses `trip` and `trip_clear` together and requires that the shutdown survive. Only a later clear with `trip` low may start the G+1 edge count to turn-on.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   typedef struct packed {
      logic hi;
      logic lo;
   } gate_pair_t;

   localparam gate_pair_t GATES_OFF = '{hi: 1'b0, lo: 1'b0};

   function automatic gate_pair_t side_for(input logic cmd);
      gate_pair_t g;
      g.hi = cmd;
      g.lo = ~cmd;
      return g;
   endfunction

endpackage

// File: rtl/cpwm_trip_latch.sv
module cpwm_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic trip_clear,
   output logic block
);
   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= trip | (held_q & ~trip_clear);
   end

   // the clearing edge itself still blocks; release takes effect one edge later
   assign block = trip | held_q;
endmodule

// File: rtl/cpwm_gap_timer.sv
module cpwm_gap_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] limit,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   assign expired = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_cmd,
   input  logic [GAP_W-1:0] gap_cycles,
   input  logic             trip,
   input  logic             trip_clear,
   output logic             gate_hi,
   output logic             gate_lo
);
   import cpwm_pkg::*;

   generate
      if (GAP_W < 1 || GAP_W > 24) begin : g_bad_width
         $error("cpwm_deadband: GAP_W must lie in 1..24");
      end
   endgenerate

   logic       block;
   logic       served_q;
   logic       restart;
   logic       expired;
   gate_pair_t gates_q, gates_d;

   cpwm_trip_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .trip       (trip),
      .trip_clear (trip_clear),
      .block      (block)
   );

   // a new command level or an active shutdown restarts the idle count
   assign restart = block | (pwm_cmd ^ served_q);

   cpwm_gap_timer #(.W(GAP_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (gap_cycles),
      .expired (expired)
   );

   always_comb begin
      gates_d = gates_q;
      if (restart)
         gates_d = GATES_OFF;
      else if (gates_q == GATES_OFF && expired)
         gates_d = side_for(served_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         served_q <= 1'b0;
         gates_q  <= GATES_OFF;
      end else begin
         served_q <= pwm_cmd;
         gates_q  <= gates_d;
      end
   end

   assign gate_hi = gates_q.hi;
   assign gate_lo = gates_q.lo;
endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk #(
   parameter int GAP_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwm_cmd,
   input logic [GAP_W-1:0] gap_cycles,
   input logic             trip,
   input logic             trip_clear,
   input logic             gate_hi,
   input logic             gate_lo
);
   logic [GAP_W:0] off_run;
   logic           trip_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 off_run <= '0;
      else if (gate_hi | gate_lo) off_run <= '0;
      else if (off_run != '1)     off_run <= off_run + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trip_seen <= 1'b0;
      else        trip_seen <= trip | (trip_seen & ~trip_clear);
   end

   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   assert_hi_matches_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      gate_hi |-> $past(pwm_cmd));

   assert_lo_matches_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      gate_lo |-> !$past(pwm_cmd));

   assert_hi_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi && !pwm_cmd) |=> !gate_hi);

   assert_lo_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_lo && pwm_cmd) |=> !gate_lo);

   assert_hi_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> (off_run > {1'b0, $past(gap_cycles)}));

   assert_lo_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo) |-> (off_run > {1'b0, $past(gap_cycles)}));

   assert_trip_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> (!gate_hi && !gate_lo));

   assert_latched_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trip_seen |-> (!gate_hi && !gate_lo));
endmodule

bind cpwm_deadband cpwm_deadband_chk #(.GAP_W(GAP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwm_cmd    (pwm_cmd),
   .gap_cycles (gap_cycles),
   .trip       (trip),
   .trip_clear (trip_clear),
   .gate_hi    (gate_hi),
   .gate_lo    (gate_lo)
);

// File: tb/cpwm_deadband_bench.sv
module cpwm_deadband_bench;
   localparam int GW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwm_cmd = 1'b0;
   logic [GW-1:0] gap_cycles = 8'd3;
   logic          trip = 1'b0;
   logic          trip_clear = 1'b0;
   logic          gate_hi, gate_lo;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cpwm_deadband #(.GAP_W(GW)) u_cpwm_deadband (
      .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .gap_cycles(gap_cycles),
      .trip(trip), .trip_clear(trip_clear), .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   // {gap G, high length, low length}
   localparam int NV = 7;
   localparam int VEC [NV][3] = '{
      '{0, 5, 5},    // R9 zero gap
      '{1, 6, 4},
      '{3, 10, 8},
      '{7, 20, 12},
      '{2, 3, 9},    // R5 high level exactly G+1
      '{5, 4, 10},   // R5 high level shorter than G+1
      '{4, 2, 3}     // R5 both levels too short
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int drive_len(input int len, input int g);
      return (len > g + 1) ? len - g - 1 : 0;
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // run one command level for len cycles; command is set at the current negedge
   task automatic run_level(input bit lvl, input int len, input int g, input string tag);
      int on_cnt = 0, wrong_cnt = 0, overlap = 0, first = -1;
      pwm_cmd = lvl;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (gate_hi && gate_lo) overlap++;
         if (i == 0) check((lvl ? gate_lo : gate_hi) == 1'b0, "R3 outgoing off",
                           int'(lvl ? gate_lo : gate_hi), 0);
         if (lvl ? gate_hi : gate_lo) begin
            on_cnt++;
            if (first < 0) first = i;
         end
         if (lvl ? gate_lo : gate_hi) wrong_cnt++;
      end
      check(on_cnt == drive_len(len, g), {tag, " drive cycles"}, on_cnt, drive_len(len, g));
      check(first == ((len > g + 1) ? g + 1 : -1), {tag, " R4 first on"}, first,
            (len > g + 1) ? g + 1 : -1);
      check(wrong_cnt == 0, "R1 opposite side stays off", wrong_cnt, 0);
      check(overlap == 0, "R2 overlap", overlap, 0);
   endtask

   initial begin
      int first;
      // R10 reset state
      repeat (3) @(negedge clk);
      check(!gate_hi && !gate_lo, "R10 reset state", {gate_hi, gate_lo}, 0);
      rst_n = 1'b1;
      first = -1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (gate_lo && first < 0) first = i;
      end
      check(first == 3, "R10 first turn-on after reset", first, 3);

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         gap_cycles = GW'(VEC[v][0]);
         run_level(1'b1, VEC[v][1], VEC[v][0], (v >= 4) ? "R5 high" : "R4 high");
         run_level(1'b0, VEC[v][2], VEC[v][0], (v >= 4) ? "R5 low" : "R4 low");
         repeat (VEC[v][0] + 2) @(negedge clk);   // settle on low side
      end

      // trip at the same edge as a command change
      gap_cycles = 8'd4;
      pwm_cmd = 1'b1;
      repeat (12) @(negedge clk);
      check(gate_hi == 1'b1, "R1 high side driving", gate_hi, 1);
      pwm_cmd = 1'b0;
      trip = 1'b1;
      @(negedge clk);
      check(!gate_hi && !gate_lo, "R6 trip forces off", {gate_hi, gate_lo}, 0);
      trip = 1'b0;
      first = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (gate_hi || gate_lo) first++;
      end
      check(first == 0, "R7 shutdown latched", first, 0);
      // clear while trip still high is ignored
      trip = 1'b1;
      trip_clear = 1'b1;
      @(negedge clk);
      trip = 1'b0;
      trip_clear = 1'b0;
      first = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (gate_hi || gate_lo) first++;
      end
      check(first == 0, "R7 clear during trip ignored", first, 0);
      // real clear
      trip_clear = 1'b1;
      @(negedge clk);
      trip_clear = 1'b0;
      check(!gate_hi && !gate_lo, "R8 off at clear edge", {gate_hi, gate_lo}, 0);
      first = -1;
      for (int j = 1; j < 12; j++) begin
         @(negedge clk);
         if (gate_lo && first < 0) first = j;
      end
      check(first == 5, "R8 turn-on after clear", first, 5);

      // asynchronous reset mid-run
      check(gate_lo == 1'b1, "R1 low side driving", gate_lo, 1);
      rst_n = 1'b0;
      #1;
      check(!gate_hi && !gate_lo, "R10 async reset", {gate_hi, gate_lo}, 0);
      @(negedge clk);
      done = 1'b1;
      summary();
   end

   initial begin
      #(4 * 50000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end
endmodule